// File: doc/BRIEF.md
# FM Synth Timer and Busy Unit

This block keeps the two interval timers of an FM sound generator and the flag that tells a host the chip is still absorbing its last register write. It does not count master cycles itself for the timers. Instead it follows an operator-slot strobe from the chip's slot sequencer. Twenty-four strobes make one round, and in normal operation one round lasts 144 master cycles. Timer A may act once per round. Timer B may act once every sixteen rounds.

A host writes an address and a data byte through one write port. Four addresses are decoded: the two halves of Timer A's 10-bit load value, Timer B's 8-bit load value, and a control register that enables the timers and clears their overflow flags. Every write, whatever its address, makes the busy bit high for a fixed number of master cycles. The status byte gives the busy bit and the two overflow flags.

Top module: `fm_timer_busy`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) makes the status byte 0x00, zeroes both counters and all load and control state, and puts the slot position back at the first strobe of a round.
- R2: A write accepted at a clock edge sets status bit 7 (busy) from that edge on. The bit stays high for exactly 17 clock cycles and then reads 0.
- R3: A write accepted while busy is high starts the 17-cycle busy window again from that write.
- R4: A round is 24 slot strobes. Timers are evaluated only on the first strobe of a round, and never on the other 23.
- R5: Timer A is enabled by bit 0 of the control register at address 0x27. When it is evaluated, a nonzero count decrements and a zero count reloads from its load value and sets status bit 0. With load value L, the flag therefore recurs every L+1 rounds.
- R6: Timer B is enabled by bit 1 of 0x27. It is evaluated only on the first strobe of rounds whose index modulo 16 is 0, and the first round after reset has index 0. It follows the same decrement-or-reload rule, and a reload sets status bit 1. With load value L, the flag recurs every 16*(L+1) rounds.
- R7: Overflow flags are sticky. A write to 0x27 with bit 4 set clears flag A, and a write with bit 5 set clears flag B. If a reload happens in the same cycle as a clear, the flag stays set.
- R8: Clearing a timer's enable bit freezes its count and leaves its overflow flag as it was.
- R9: Address 0x24 holds the upper 8 bits of Timer A's 10-bit load value and bits [1:0] of address 0x25 hold the lower 2 bits. Address 0x26 holds Timer B's load value. Writes to any other address leave both timers unchanged.
- R10: Status bits 6 to 2 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| slot_tick | input | 1 | One-cycle strobe marking the end of one operator slot |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register address |
| wr_data | input | 8 | Register write data |
| status | output | 8 | Bit 7 busy, bit 1 Timer B flag, bit 0 Timer A flag |

## Verification
Every result comes from a register. Busy is high from the edge that accepts a write and is low again after the seventeenth following edge. A flag changes on the edge that samples the round-opening strobe. The bench drives each strobe and write for exactly one cycle, starting on a falling edge. It then reads status on the falling edge right after the sampling edge. Busy is checked on each of the 17 falling edges of its window and on the one just after it. Timer periods are measured by stepping whole rounds. The bench checks that a flag is still clear after the round before the predicted reload and is set after the round in which the reload falls.

// File: rtl/fm_tmr_pkg.sv
package fm_tmr_pkg;

   localparam logic [7:0] ADDR_TA_HI = 8'h24;
   localparam logic [7:0] ADDR_TA_LO = 8'h25;
   localparam logic [7:0] ADDR_TB    = 8'h26;
   localparam logic [7:0] ADDR_CTRL  = 8'h27;

   localparam int CTL_EN_A  = 0;
   localparam int CTL_EN_B  = 1;
   localparam int CTL_CLR_A = 4;
   localparam int CTL_CLR_B = 5;

   localparam int STS_FLAG_A = 0;
   localparam int STS_FLAG_B = 1;
   localparam int STS_BUSY   = 7;

   typedef struct packed {
      logic en_a;
      logic en_b;
   } tmr_ctl_t;

endpackage

// File: rtl/fm_slot_seq.sv
module fm_slot_seq #(
   parameter int SLOTS = 24,
   parameter int B_DIV = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic slot_tick,
   output logic eval_a,
   output logic eval_b
);
   localparam int SLOT_W = $clog2(SLOTS);
   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

   logic [SLOT_W-1:0] slot_idx;
   logic              round_end;
   logic              first_round;

   if (SLOTS < 2) begin : g_chk_slots
      $error("fm_slot_seq: SLOTS must be at least 2");
   end
   if (B_DIV < 1) begin : g_chk_div
      $error("fm_slot_seq: B_DIV must be at least 1");
   end

   assign round_end = slot_tick && (slot_idx == LAST_SLOT);

   always_ff @(posedge clk) begin
      if (rst)
         slot_idx <= '0;
      else if (slot_tick)
         slot_idx <= (slot_idx == LAST_SLOT) ? '0 : slot_idx + 1'b1;
   end

   if (B_DIV > 1) begin : g_div
      localparam int RW = $clog2(B_DIV);
      localparam logic [RW-1:0] LAST_ROUND = RW'(B_DIV - 1);
      logic [RW-1:0] round_idx;

      always_ff @(posedge clk) begin
         if (rst)
            round_idx <= '0;
         else if (round_end)
            round_idx <= (round_idx == LAST_ROUND) ? '0 : round_idx + 1'b1;
      end
      assign first_round = (round_idx == '0);

      AST_ROUND_HOLD: assert property (@(posedge clk) disable iff (rst)
         !round_end |=> $stable(round_idx)); // R6
   end else begin : g_nodiv
      assign first_round = 1'b1;
   end

   assign eval_a = slot_tick && (slot_idx == '0);
   assign eval_b = eval_a && first_round;

   AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (rst)
      !slot_tick |=> $stable(slot_idx)); // R4
   AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (rst)
      round_end |=> (slot_idx == '0)); // R4

endmodule

// File: rtl/fm_interval_timer.sv
module fm_interval_timer #(
   parameter int W = 10
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         eval,
   input  logic         en,
   input  logic [W-1:0] load,
   input  logic         clr_flag,
   output logic         flag
);
   logic [W-1:0] cnt;
   logic         step;
   logic         wrap;

   if (W < 1) begin : g_chk_w
      $error("fm_interval_timer: W must be positive");
   end

   assign step = eval && en;
   assign wrap = step && (cnt == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt  <= '0;
         flag <= 1'b0;
      end else begin
         if (step)
            cnt <= (cnt == '0) ? load : cnt - 1'b1;
         if (wrap)
            flag <= 1'b1;
         else if (clr_flag)
            flag <= 1'b0;
      end
   end

   AST_TMR_HOLD: assert property (@(posedge clk) disable iff (rst)
      !(eval && en) |=> $stable(cnt)); // R8
   AST_TMR_STEP: assert property (@(posedge clk) disable iff (rst)
      (eval && en && cnt != '0) |=> (cnt == $past(cnt) - W'(1))); // R5
   AST_TMR_RELOAD: assert property (@(posedge clk) disable iff (rst)
      (eval && en && cnt == '0) |=> (flag && cnt == $past(load))); // R5
   AST_TMR_STICKY: assert property (@(posedge clk) disable iff (rst)
      (flag && !clr_flag) |=> flag); // R7

endmodule

// File: rtl/fm_busy_ctr.sv
module fm_busy_ctr #(
   parameter int CYCLES = 17
) (
   input  logic clk,
   input  logic rst,
   input  logic wr_pulse,
   output logic busy
);
   localparam int BW = $clog2(CYCLES + 1);
   localparam logic [BW-1:0] START = BW'(CYCLES);

   logic [BW-1:0] cnt;

   if (CYCLES < 1) begin : g_chk_cyc
      $error("fm_busy_ctr: CYCLES must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (rst)
         cnt <= '0;
      else if (wr_pulse)
         cnt <= START;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign busy = (cnt != '0);

   AST_BUSY_RISE: assert property (@(posedge clk) disable iff (rst)
      wr_pulse |=> busy); // R2
   AST_BUSY_FALL: assert property (@(posedge clk) disable iff (rst)
      (cnt == BW'(1) && !wr_pulse) |=> !busy); // R2
   AST_BUSY_RESTART: assert property (@(posedge clk) disable iff (rst)
      wr_pulse |=> (cnt == START)); // R3

endmodule

// File: rtl/fm_timer_busy.sv
module fm_timer_busy
   import fm_tmr_pkg::*;
#(
   parameter int TA_W            = 10,
   parameter int TB_W            = 8,
   parameter int SLOTS_PER_ROUND = 24,
   parameter int B_ROUND_DIV     = 16,
   parameter int BUSY_CYCLES     = 17
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       slot_tick,
   input  logic       wr_en,
   input  logic [7:0] wr_addr,
   input  logic [7:0] wr_data,
   output logic [7:0] status
);
   localparam int TA_LO_W = TA_W - 8;

   if (TA_W < 9 || TA_W > 16) begin : g_chk_ta
      $error("fm_timer_busy: TA_W must lie in 9..16");
   end
   if (TB_W < 1 || TB_W > 8) begin : g_chk_tb
      $error("fm_timer_busy: TB_W must lie in 1..8");
   end

   logic [7:0]         ta_hi;
   logic [TA_LO_W-1:0] ta_lo;
   logic [TB_W-1:0]    tb_load;
   tmr_ctl_t           ctl;
   logic               wr_ctrl;
   logic               clr_a, clr_b;
   logic               eval_a, eval_b;
   logic               flag_a, flag_b;
   logic               busy;

   assign wr_ctrl = wr_en && (wr_addr == ADDR_CTRL);
   assign clr_a   = wr_ctrl && wr_data[CTL_CLR_A];
   assign clr_b   = wr_ctrl && wr_data[CTL_CLR_B];

   always_ff @(posedge clk) begin
      if (rst) begin
         ta_hi   <= '0;
         ta_lo   <= '0;
         tb_load <= '0;
         ctl     <= '0;
      end else if (wr_en) begin
         unique case (wr_addr)
            ADDR_TA_HI: ta_hi   <= wr_data;
            ADDR_TA_LO: ta_lo   <= wr_data[TA_LO_W-1:0];
            ADDR_TB:    tb_load <= wr_data[TB_W-1:0];
            ADDR_CTRL: begin
               ctl.en_a <= wr_data[CTL_EN_A];
               ctl.en_b <= wr_data[CTL_EN_B];
            end
            default: ;
         endcase
      end
   end

   fm_slot_seq #(
      .SLOTS (SLOTS_PER_ROUND),
      .B_DIV (B_ROUND_DIV)
   ) seq_i (
      .clk       (clk),
      .rst       (rst),
      .slot_tick (slot_tick),
      .eval_a    (eval_a),
      .eval_b    (eval_b)
   );

   fm_interval_timer #(.W(TA_W)) tmr_a_i (
      .clk      (clk),
      .rst      (rst),
      .eval     (eval_a),
      .en       (ctl.en_a),
      .load     ({ta_hi, ta_lo}),
      .clr_flag (clr_a),
      .flag     (flag_a)
   );

   fm_interval_timer #(.W(TB_W)) tmr_b_i (
      .clk      (clk),
      .rst      (rst),
      .eval     (eval_b),
      .en       (ctl.en_b),
      .load     (tb_load),
      .clr_flag (clr_b),
      .flag     (flag_b)
   );

   fm_busy_ctr #(.CYCLES(BUSY_CYCLES)) busy_i (
      .clk      (clk),
      .rst      (rst),
      .wr_pulse (wr_en),
      .busy     (busy)
   );

   always_comb begin
      status             = '0;
      status[STS_BUSY]   = busy;
      status[STS_FLAG_B] = flag_b;
      status[STS_FLAG_A] = flag_a;
   end

   AST_NONCTRL_KEEPS_EN: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_addr != ADDR_CTRL) |=> $stable(ctl)); // R9
   AST_FLAG_A_NEEDS_EVAL: assert property (@(posedge clk) disable iff (rst)
      (!eval_a && !flag_a) |=> !flag_a); // R4

endmodule

// File: tb/fm_timer_busy_tb_top.sv
module fm_timer_busy_tb_top;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       slot_tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] status;

   int n_vec = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   fm_timer_busy dut_i (
      .clk       (clk),
      .rst       (rst),
      .slot_tick (slot_tick),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .status    (status)
   );

   localparam int NV = 4;
   localparam int VEC_LOAD [NV] = '{0, 2, 7, 259};
   localparam int VEC_PER  [NV] = '{1, 3, 8, 260};

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic tick_slots(input int n);
      for (int i = 0; i < n; i++) begin
         slot_tick = 1'b1;
         @(negedge clk);
         slot_tick = 1'b0;
         repeat (5) @(negedge clk);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      do_reset();
      chk("R1 reset status", status, 8'h00);

      // R5 / R9 table: period of Timer A flag versus load value
      for (int v = 0; v < NV; v++) begin
         do_reset();
         wr(8'h24, 8'((VEC_LOAD[v] >> 2) & 8'hFF));
         wr(8'h25, 8'(VEC_LOAD[v] & 3));
         wr(8'h27, 8'h01);
         tick_slots(1);
         chk("R5 first reload flag", {7'd0, status[0]}, 8'h01);
         tick_slots(23);
         wr(8'h27, 8'h11);
         chk("R7 clear flag A", {7'd0, status[0]}, 8'h00);
         for (int r = 1; r <= VEC_PER[v]; r++) begin
            tick_slots(24);
            if (r == VEC_PER[v] - 1)
               chk("R5 R9 flag A early", {7'd0, status[0]}, 8'h00);
         end
         chk("R5 R9 flag A period", {7'd0, status[0]}, 8'h01);
      end

      // R4: evaluation only at first strobe of a round
      do_reset();
      wr(8'h27, 8'h01);
      tick_slots(1);
      chk("R4 eval at slot 0", {7'd0, status[0]}, 8'h01);
      wr(8'h27, 8'h11);
      tick_slots(23);
      chk("R4 no eval in slots 1..23", {7'd0, status[0]}, 8'h00);
      tick_slots(1);
      chk("R4 eval at next round", {7'd0, status[0]}, 8'h01);

      // R8: disable keeps flag, freezes count
      wr(8'h27, 8'h00);
      chk("R8 flag kept on disable", {7'd0, status[0]}, 8'h01);
      wr(8'h27, 8'h10);
      tick_slots(48);
      chk("R8 frozen while disabled", {7'd0, status[0]}, 8'h00);

      // R6: Timer B every 16 rounds per count
      do_reset();
      wr(8'h26, 8'h01);
      wr(8'h27, 8'h02);
      tick_slots(1);
      chk("R6 B first reload", {6'd0, status[1:0]}, 8'h02);
      tick_slots(23);
      wr(8'h27, 8'h22);
      chk("R7 clear flag B", {6'd0, status[1:0]}, 8'h00);
      tick_slots(31 * 24);
      chk("R6 B not before round 32", {6'd0, status[1:0]}, 8'h00);
      tick_slots(1);
      chk("R6 B reload at round 32", {6'd0, status[1:0]}, 8'h02);
      chk("R10 spare status bits", {3'd0, status[6:2]}, 8'h00);

      // R9: unrelated addresses do not touch timers
      do_reset();
      wr(8'h28, 8'hFF);
      wr(8'h23, 8'hFF);
      tick_slots(24);
      chk("R9 other addresses ignored", {6'd0, status[1:0]}, 8'h00);

      // R2: busy window length
      do_reset();
      wr(8'h30, 8'h00);
      for (int i = 0; i < 17; i++) begin
         chk("R2 busy held", {7'd0, status[7]}, 8'h01);
         @(negedge clk);
      end
      chk("R2 busy released", {7'd0, status[7]}, 8'h00);

      // R3: restart during busy
      wr(8'h24, 8'h00);
      repeat (10) @(negedge clk);
      wr(8'h24, 8'h00);
      for (int i = 0; i < 17; i++) begin
         chk("R3 busy restarted", {7'd0, status[7]}, 8'h01);
         @(negedge clk);
      end
      chk("R3 busy released", {7'd0, status[7]}, 8'h00);
      chk("R10 spare bits idle", {3'd0, status[6:2]}, 8'h00);

      // R1: reset clears active state and slot position
      wr(8'h27, 8'h01);
      tick_slots(5);
      wr(8'h27, 8'h01);
      rst = 1'b1;
      @(negedge clk);
      chk("R1 reset clears busy and flags", status, 8'h00);
      rst = 1'b0;
      wr(8'h27, 8'h01);
      tick_slots(1);
      chk("R1 slot position restarted", {7'd0, status[0]}, 8'h01);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule